// File: doc/BRIEF.md
# Memory-to-Memory Byte Move Sequencer

This block carries out one single-byte memory-to-memory move for a small 8-bit processor core, with no use of the accumulator. After a start strobe it looks at the move opcode and then performs the needed accesses, one at a time, over a single byte-wide memory port. It reads the operand bytes that follow the opcode in program memory. When the source is not an immediate value, it reads the source byte. It then writes that byte to the destination. Two of the four variants address memory through the 16-bit index pair H:X. Those two variants return H:X plus one as a writeback when the move ends.

The memory port is stream-like. The request channel carries `req_valid`/`req_ready`. A request offered while `req_ready` is low must be held unchanged, with the same address, write flag and write data, until a cycle in which `req_ready` is high; that cycle completes the handshake. Every accepted read is answered later by exactly one `rsp_valid` cycle carrying `rsp_rdata`. The response channel cannot be back-pressured, and at most one read is outstanding at a time. The caller supplies the address of the first operand byte (`oper_addr`, the byte after the opcode) and the current H:X. The caller sees `done`, or `err` when the opcode is not a move, and updates H:X when `hx_we` is high.

Top module: `mm_move_seq`

## Requirements
- R1: While reset is held and just after it is released, `req_valid`, `done`, `err` and `hx_we` are low.
- R2: Opcode 0x6E (immediate to page zero) reads `oper_addr`, giving the data, then `oper_addr+1`, giving the destination low byte D. It then writes the data to {0x00,D}.
- R3: Opcode 0x4E (page zero to page zero) reads `oper_addr`, giving source low byte S, then `oper_addr+1`, giving D. It then reads {0x00,S} and writes that byte to {0x00,D}.
- R4: Opcode 0x7E (indexed with post-increment to page zero) reads `oper_addr`, giving D, then reads the byte at H:X, writes it to {0x00,D}, and returns H:X+1.
- R5: Opcode 0x5E (page zero to indexed with post-increment) reads `oper_addr`, giving S, then reads {0x00,S}, writes that byte to H:X, and returns H:X+1.
- R6: The returned H:X wraps from 0xFFFF to 0x0000. Operand addresses `oper_addr+1` also wrap modulo 2^16.
- R7: `hx_we` pulses high together with `done` only for opcodes 0x7E and 0x5E. For 0x6E and 0x4E it stays low.
- R8: Accesses are issued in the order operand bytes (increasing address), then source read, then destination write. Exactly one write is issued per move.
- R9: A request not accepted because `req_ready` is low stays valid with address, write flag and write data unchanged in the next cycle.
- R10: For any opcode other than the four above, `err` pulses for one cycle in the cycle after the start is taken. No request is issued and `done` stays low.
- R11: A start strobe while a move is in progress is ignored: the running move's accesses and result are unaffected and no second move follows.
- R12: `done` pulses for exactly one cycle, in the cycle after the write request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a move (taken only when idle) |
| opcode | input | 8 | Move opcode, sampled with start |
| oper_addr | input | 16 | Address of the first operand byte, sampled with start |
| hx_in | input | 16 | Current H:X, sampled with start |
| req_valid | output | 1 | Memory request offered |
| req_ready | input | 1 | Memory accepts the request this cycle |
| req_addr | output | 16 | Request address |
| req_we | output | 1 | 1 = write, 0 = read |
| req_wdata | output | 8 | Write data |
| rsp_valid | input | 1 | Read data returned this cycle |
| rsp_rdata | input | 8 | Read data |
| hx_out | output | 16 | H:X writeback value, valid with hx_we |
| hx_we | output | 1 | H:X writeback strobe |
| done | output | 1 | Move completed |
| err | output | 1 | Start carried an opcode that is not a move |

## Verification
A wrong step register in the sequencer shows at the ports as a request to the wrong address, or as a read where a write was due, at the very next handshake. The bench logs every handshake and compares the whole access list of each move. Corrupted operand or source captures show as a wrong write address or write data on the final write, no later than the move's last access. A wrong H:X latch shows in `hx_out` at `done`. A state machine that loses its way leaves `done` missing, which the bench's per-move timeout reports.

// File: rtl/mm_move_pkg.sv
package mm_move_pkg;

  localparam logic [7:0] OPC_IMM_DIR = 8'h6E;
  localparam logic [7:0] OPC_DIR_DIR = 8'h4E;
  localparam logic [7:0] OPC_IDX_DIR = 8'h7E;
  localparam logic [7:0] OPC_DIR_IDX = 8'h5E;

  // access step within one move, in issue order
  typedef enum logic [1:0] {
    STEP_OPA = 2'd0,
    STEP_OPB = 2'd1,
    STEP_SRC = 2'd2,
    STEP_WR  = 2'd3
  } step_e;

  typedef enum logic [1:0] {
    CST_IDLE = 2'd0,
    CST_REQ  = 2'd1,
    CST_RSP  = 2'd2
  } cst_e;

  // what a given opcode needs
  typedef struct packed {
    logic valid;      // one of the four moves
    logic two_ops;    // two operand bytes follow the opcode
    logic src_read;   // source byte comes from memory, not the operand
    logic src_idx;    // source address is H:X
    logic dst_idx;    // destination address is H:X
    logic hx_update;  // H:X post-increment written back
  } mv_plan_t;

endpackage

// File: rtl/mm_move_decode.sv
module mm_move_decode
  import mm_move_pkg::*;
(
  input  logic [7:0] opcode,
  output mv_plan_t   plan
);

  always_comb begin
    plan = '0;
    unique case (opcode)
      OPC_IMM_DIR: plan = '{valid: 1'b1, two_ops: 1'b1, src_read: 1'b0,
                            src_idx: 1'b0, dst_idx: 1'b0, hx_update: 1'b0};
      OPC_DIR_DIR: plan = '{valid: 1'b1, two_ops: 1'b1, src_read: 1'b1,
                            src_idx: 1'b0, dst_idx: 1'b0, hx_update: 1'b0};
      OPC_IDX_DIR: plan = '{valid: 1'b1, two_ops: 1'b0, src_read: 1'b1,
                            src_idx: 1'b1, dst_idx: 1'b0, hx_update: 1'b1};
      OPC_DIR_IDX: plan = '{valid: 1'b1, two_ops: 1'b0, src_read: 1'b1,
                            src_idx: 1'b0, dst_idx: 1'b1, hx_update: 1'b1};
      default:     plan = '0;
    endcase
  end

endmodule

// File: rtl/mm_move_addr.sv
module mm_move_addr
  import mm_move_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  step_e          step,
  input  mv_plan_t       plan,
  input  logic [AW-1:0]  base,
  input  logic [AW-1:0]  hx,
  input  logic [DW-1:0]  opa,
  input  logic [DW-1:0]  opb,
  output logic [AW-1:0]  addr,
  output logic           is_write
);

  logic [AW-1:0] zx_opa;
  logic [AW-1:0] zx_opb;

  // page-zero operands: high address bits forced to zero
  generate
    if (AW > DW) begin : g_zext
      assign zx_opa = {{(AW-DW){1'b0}}, opa};
      assign zx_opb = {{(AW-DW){1'b0}}, opb};
    end else begin : g_trunc
      assign zx_opa = opa[AW-1:0];
      assign zx_opb = opb[AW-1:0];
    end
  endgenerate

  always_comb begin
    is_write = 1'b0;
    unique case (step)
      STEP_OPA: addr = base;
      STEP_OPB: addr = base + AW'(1);
      STEP_SRC: addr = plan.src_idx ? hx : zx_opa;
      default: begin
        is_write = 1'b1;
        if (plan.dst_idx)      addr = hx;
        else if (plan.two_ops) addr = zx_opb;
        else                   addr = zx_opa;
      end
    endcase
  end

endmodule

// File: rtl/mm_move_ctrl.sv
module mm_move_ctrl
  import mm_move_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  mv_plan_t plan_new,
  input  mv_plan_t plan_q,
  input  logic     req_ready,
  input  logic     rsp_valid,
  output logic     req_valid,
  output step_e    step,
  output logic     accept,
  output logic     cap,
  output logic     wr_fire,
  output logic     done,
  output logic     err
);

  cst_e  st;
  step_e nxt_step;

  always_comb begin
    unique case (step)
      STEP_OPA: nxt_step = plan_q.two_ops  ? STEP_OPB :
                           (plan_q.src_read ? STEP_SRC : STEP_WR);
      STEP_OPB: nxt_step = plan_q.src_read ? STEP_SRC : STEP_WR;
      default:  nxt_step = STEP_WR;
    endcase
  end

  assign req_valid = (st == CST_REQ);
  assign accept    = (st == CST_IDLE) && start && plan_new.valid;
  assign cap       = (st == CST_RSP) && rsp_valid;
  assign wr_fire   = (st == CST_REQ) && req_ready && (step == STEP_WR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= CST_IDLE;
      step <= STEP_OPA;
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (st)
        CST_IDLE: begin
          if (start) begin
            if (plan_new.valid) begin
              st   <= CST_REQ;
              step <= STEP_OPA;
            end else begin
              err <= 1'b1;
            end
          end
        end
        CST_REQ: begin
          if (req_ready) begin
            if (step == STEP_WR) begin
              st   <= CST_IDLE;
              done <= 1'b1;
            end else begin
              st <= CST_RSP;
            end
          end
        end
        default: begin
          if (rsp_valid) begin
            st   <= CST_REQ;
            step <= nxt_step;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/mm_move_seq.sv
module mm_move_seq
  import mm_move_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    opcode,
  input  logic [AW-1:0] oper_addr,
  input  logic [AW-1:0] hx_in,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  output logic          req_we,
  output logic [DW-1:0] req_wdata,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] hx_out,
  output logic          hx_we,
  output logic          done,
  output logic          err
);

  mv_plan_t      plan_new;
  mv_plan_t      plan_q;
  step_e         step;
  logic          accept;
  logic          cap;
  logic          wr_fire;
  logic [AW-1:0] base_q;
  logic [AW-1:0] hx_q;
  logic [DW-1:0] opa_q;
  logic [DW-1:0] opb_q;
  logic [DW-1:0] data_q;
  logic [AW-1:0] hx_out_q;
  logic          hx_we_q;

  mm_move_decode u_dec (
    .opcode (opcode),
    .plan   (plan_new)
  );

  mm_move_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .plan_new  (plan_new),
    .plan_q    (plan_q),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .req_valid (req_valid),
    .step      (step),
    .accept    (accept),
    .cap       (cap),
    .wr_fire   (wr_fire),
    .done      (done),
    .err       (err)
  );

  mm_move_addr #(.AW(AW), .DW(DW)) u_addr (
    .step     (step),
    .plan     (plan_q),
    .base     (base_q),
    .hx       (hx_q),
    .opa      (opa_q),
    .opb      (opb_q),
    .addr     (req_addr),
    .is_write (req_we)
  );

  // move context, captured when a move is taken
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      plan_q <= '0;
      base_q <= '0;
      hx_q   <= '0;
    end else if (accept) begin
      plan_q <= plan_new;
      base_q <= oper_addr;
      hx_q   <= hx_in;
    end
  end

  // operand and data capture from read responses
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opa_q  <= '0;
      opb_q  <= '0;
      data_q <= '0;
    end else if (cap) begin
      unique case (step)
        STEP_OPA: begin
          opa_q <= rsp_rdata;
          if (!plan_q.src_read) data_q <= rsp_rdata;
        end
        STEP_OPB: opb_q  <= rsp_rdata;
        default:  data_q <= rsp_rdata;
      endcase
    end
  end

  // H:X post-increment writeback, aligned with done
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hx_out_q <= '0;
      hx_we_q  <= 1'b0;
    end else begin
      hx_we_q <= 1'b0;
      if (wr_fire && plan_q.hx_update) begin
        hx_out_q <= hx_q + AW'(1);
        hx_we_q  <= 1'b1;
      end
    end
  end

  assign req_wdata = data_q;
  assign hx_out    = hx_out_q;
  assign hx_we     = hx_we_q;

endmodule

// File: rtl/mm_move_seq_chk.sv
module mm_move_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic          req_we,
  input logic [DW-1:0] req_wdata,
  input logic          hx_we,
  input logic          done,
  input logic          err
);

  // R9: a stalled request is held unchanged
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr)
                                && $stable(req_we) && $stable(req_wdata));

  // R12: done follows an accepted write by one cycle
  p_done_after_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(req_valid && req_ready && req_we));

  // R12: done lasts one cycle
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: writeback strobe only together with done
  p_hxwe_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hx_we |-> done);

  // R10: error pulse follows a start and issues nothing
  p_err_after_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(start) && !req_valid && !done);

endmodule

bind mm_move_seq mm_move_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .req_we    (req_we),
  .req_wdata (req_wdata),
  .hx_we     (hx_we),
  .done      (done),
  .err       (err)
);

// File: tb/tb_mm_move_seq.sv
module tb_mm_move_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [15:0] oper_addr = 16'h0000;
  logic [15:0] hx_in = 16'h0000;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [15:0] req_addr;
  logic        req_we;
  logic [7:0]  req_wdata;
  logic        rsp_valid = 1'b0;
  logic [7:0]  rsp_rdata = 8'h00;
  logic [15:0] hx_out;
  logic        hx_we;
  logic        done;
  logic        err;

  always #2 clk = ~clk;  // 250 MHz

  mm_move_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .oper_addr(oper_addr), .hx_in(hx_in), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_we(req_we),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .hx_out(hx_out), .hx_we(hx_we), .done(done), .err(err)
  );

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;

  // memory model: contents are a function of the address
  function automatic logic [7:0] mval(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  // handshake log
  logic [15:0] lg_addr [8];
  logic        lg_we   [8];
  logic [7:0]  lg_wd   [8];
  int          lg_n = 0;
  int          rmod = 0;
  int          lat = 0;
  int          pend = -1;
  logic [7:0]  pend_d = 8'h00;

  // memory responder, all driving at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      rsp_valid = 1'b0;
      if (pend == 0) begin
        rsp_valid = 1'b1;
        rsp_rdata = pend_d;
        pend = -1;
      end else if (pend > 0) begin
        pend--;
      end
      req_ready = (rmod == 0) ? 1'b1 : ((cyc % rmod) != 0);
      if (req_valid && req_ready) begin
        if (lg_n < 8) begin
          lg_addr[lg_n] = req_addr;
          lg_we[lg_n]   = req_we;
          lg_wd[lg_n]   = req_wdata;
        end
        lg_n++;
        if (!req_we) begin
          pend   = lat;
          pend_d = mval(req_addr);
        end
      end
    end
  end

  // watchdog
  initial begin
    wait (cyc > 150000);
    n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  task automatic fail(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
    n_bad++;
    $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
  endtask

  task automatic run_move(input logic [7:0] op, input logic [15:0] pc,
                          input logic [15:0] hx, input int rm, input int lt,
                          input bit extra);
    logic [15:0] ex_addr [4];
    logic        ex_we   [4];
    logic [7:0]  ex_wd   [4];
    int          ex_n;
    bit          valid_op;
    bit          idx;
    string       tag;
    logic [15:0] s;
    int          seen_done;
    int          seen_err;
    bit          seen_hxwe;
    logic [15:0] hx_seen;
    int          lg_at_done;

    valid_op = 1'b1;
    idx = 1'b0;
    ex_n = 0;
    for (int k = 0; k < 4; k++) begin
      ex_addr[k] = '0; ex_we[k] = 1'b0; ex_wd[k] = '0;
    end
    case (op)
      8'h6E: begin
        tag = "R2";
        ex_addr[0] = pc; ex_addr[1] = pc + 16'd1;
        ex_addr[2] = {8'h00, mval(pc + 16'd1)}; ex_we[2] = 1'b1;
        ex_wd[2] = mval(pc); ex_n = 3;
      end
      8'h4E: begin
        tag = "R3";
        s = {8'h00, mval(pc)};
        ex_addr[0] = pc; ex_addr[1] = pc + 16'd1; ex_addr[2] = s;
        ex_addr[3] = {8'h00, mval(pc + 16'd1)}; ex_we[3] = 1'b1;
        ex_wd[3] = mval(s); ex_n = 4;
      end
      8'h7E: begin
        tag = "R4"; idx = 1'b1;
        ex_addr[0] = pc; ex_addr[1] = hx;
        ex_addr[2] = {8'h00, mval(pc)}; ex_we[2] = 1'b1;
        ex_wd[2] = mval(hx); ex_n = 3;
      end
      8'h5E: begin
        tag = "R5"; idx = 1'b1;
        s = {8'h00, mval(pc)};
        ex_addr[0] = pc; ex_addr[1] = s;
        ex_addr[2] = hx; ex_we[2] = 1'b1; ex_wd[2] = mval(s); ex_n = 3;
      end
      default: begin
        tag = "R10"; valid_op = 1'b0;
      end
    endcase

    rmod = rm; lat = lt; lg_n = 0;
    seen_done = 0; seen_err = 0; seen_hxwe = 1'b0; hx_seen = '0;
    lg_at_done = -1;

    @(negedge clk);
    opcode = op; oper_addr = pc; hx_in = hx; start = 1'b1;
    for (int t = 0; t < 200; t++) begin
      @(negedge clk);
      start = 1'b0;
      if (extra && t == 1) begin
        // R11: second start while busy
        start = 1'b1; opcode = 8'h6E; oper_addr = pc ^ 16'h5A5A;
      end
      if (done) begin
        seen_done++;
        if (lg_at_done < 0) lg_at_done = lg_n;
      end
      if (hx_we) begin seen_hxwe = 1'b1; hx_seen = hx_out; end
      if (err) seen_err++;
      if (t > 12 && ((valid_op && seen_done > 0) || !valid_op)) break;
    end
    start = 1'b0;
    repeat (8) @(negedge clk);
    if (done) seen_done++;

    n_vec++;
    if (!valid_op) begin
      if (seen_err != 1 || seen_done != 0 || lg_n != 0)
        fail("R10", "err/done/requests", {seen_err[7:0], seen_done[7:0], lg_n[15:0]},
             {8'd1, 8'd0, 16'd0});
    end else begin
      // R8 R12: exact access list and a single done
      if (seen_done != 1 || seen_err != 0)
        fail(tag, "R12 done count", seen_done, 1);
      else if (lg_n != ex_n || lg_at_done != ex_n)
        fail(tag, extra ? "R11 R8 access count" : "R8 access count", lg_n, ex_n);
      else begin
        for (int k = 0; k < ex_n; k++) begin
          if (lg_addr[k] != ex_addr[k] || lg_we[k] != ex_we[k] ||
              (ex_we[k] && lg_wd[k] != ex_wd[k])) begin
            fail(tag, $sformatf("R8 access %0d addr/we/wdata", k),
                 {lg_addr[k], 7'd0, lg_we[k], lg_wd[k]},
                 {ex_addr[k], 7'd0, ex_we[k], ex_wd[k]});
            break;
          end
        end
      end
      n_vec++;
      if (idx) begin
        if (!seen_hxwe || hx_seen != hx + 16'd1)
          fail(hx == 16'hFFFF ? "R6" : "R7", "H:X writeback",
               {15'd0, seen_hxwe, hx_seen}, {16'd1, hx + 16'd1});
      end else if (seen_hxwe) begin
        fail("R7", "unexpected hx_we", 1, 0);
      end
    end
  endtask

  logic [15:0] pcs [4];
  logic [15:0] hxs [4];
  int          rms [3];

  initial begin
    pcs[0] = 16'h0100; pcs[1] = 16'hFFFF; pcs[2] = 16'h8150; pcs[3] = 16'h0000;
    hxs[0] = 16'h0400; hxs[1] = 16'hFFFF; hxs[2] = 16'h0050; hxs[3] = 16'h00F0;
    rms[0] = 0; rms[1] = 2; rms[2] = 3;

    repeat (4) @(negedge clk);
    // R1: idle outputs during reset
    n_vec++;
    if (req_valid || done || err || hx_we)
      fail("R1", "outputs in reset", {req_valid, done, err, hx_we}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    n_vec++;
    if (req_valid || done || err || hx_we)
      fail("R1", "outputs after reset", {req_valid, done, err, hx_we}, 4'b0000);

    // sweep every opcode; moves under many address, stall and latency mixes
    for (int op = 0; op < 256; op++) begin
      if (op == 8'h6E || op == 8'h4E || op == 8'h7E || op == 8'h5E) begin
        for (int i = 0; i < 4; i++)
          for (int j = 0; j < 3; j++)
            run_move(8'(op), pcs[i], hxs[(i + j) % 4], rms[j], (i + j) % 3, j == 1);
      end else begin
        run_move(8'(op), 16'h1234, 16'h4321, 0, 0, 1'b0);
      end
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule